// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block gathers external interrupt lines from several GPIO banks and turns them into one interrupt request for a parent controller. The lines are organised as groups of sixteen. Two groups are packed into every 32-bit configuration, mask and pending register. Software reaches these registers over a simple single-cycle word bus.

Each line passes through a two-flop synchroniser. A trigger detector then decides whether the line should raise its pending bit. One 4-bit trigger field controls four neighbouring lines. A combined output signals that some unmasked line is pending. A service register names the line to handle next as a group and pin pair, so the interrupt handler can loop on it without scanning the pending registers. Storage group 0 covers two physical banks: one bank on pins 0–7 and a second bank on pins 8–15.

Top module: `gpio_irq_grp`

## Requirements
- R1: Word addresses: trigger register i at 0x00+i, mask register i at 0x10+i, pending register i at 0x20+i, service register at 0x30, for i from 0 to ceil(NUM_GROUPS/2)-1. A write takes effect at the clock edge where `we` is high. `rdata` shows the addressed register combinationally. Unmapped addresses read 0.
- R2: Trigger codes are: 0 = line low, 1 = line high, 2 = falling edge, 4 = rising edge, 6 = either edge.
- R3: Line l belongs to register l/32 at bit l%32. Its trigger code is the 4-bit field at bit 4*((l%32)/4) of that trigger register, so the four lines sharing that field trigger alike.
- R4: A mask bit of 1 keeps its line out of `irq` and out of the service register. The line's pending bit is still recorded.
- R5: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A set condition in the same cycle wins over the clear.
- R6: The service register holds the group in bits 7:4 and the pin in bits 3:0. The group field equals storage group (l/16) plus 1, and the pin field equals l%16. A value of 0 means nothing is waiting. Pins 8–15 of storage group 0 are reported with their pin numbers 8–15.
- R7: The service register reports the unmasked pending line with the lowest group, and the lowest pin within that group.
- R8: `irq` is high exactly when some pending bit has its mask bit at 0.
- R9: Reset puts every mask bit at 1, every pending bit and trigger field at 0, and every synchroniser stage at 1, which is the idle-high level.
- R10: A change on a line is first visible in its pending bit after the third rising clock edge following the change.
- R11: A level trigger keeps setting its pending bit while the level holds. A write-1 clear then has no lasting effect.
- R12: The codes not listed in R2 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_GROUPS*16 | Asynchronous external interrupt lines |
| we | input | 1 | Register write strobe |
| addr | input | 8 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach from the ports is one where the service register must arbitrate between lines in different groups and registers. That state needs two lines pending at once with different trigger kinds, while earlier events are still uncleared. The stimulus builds it step by step. An either-edge line in group 2 is left pending. A falling edge is then raised in group 0, and a second pin of group 2 is unmasked and toggled. The service value is read after each clear, so the arbitration order is seen across groups and within a group. A level trigger is also set up while the line already sits at the active level. This shows that a write-1 clear is overridden in the same cycle.

// File: rtl/gpio_irq_grp.sv
module gpio_irq_grp #(
  parameter int NUM_GROUPS = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_GROUPS*16-1:0]   line_in,
  input  logic                       we,
  input  logic [7:0]                 addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic                       irq
);
  localparam int NUM_LINES = NUM_GROUPS * 16;
  localparam int NUM_REGS  = (NUM_GROUPS + 1) / 2;
  localparam int REG_BITS  = NUM_REGS * 32;
  localparam int CFG_BASE  = 8'h00;
  localparam int MASK_BASE = 8'h10;
  localparam int PEND_BASE = 8'h20;
  localparam int SVC_ADDR  = 8'h30;

  logic [NUM_LINES-1:0] sync1_q, sync2_q, prev_q;
  logic [REG_BITS-1:0]  cfg_q, mask_q, pend_q;
  logic [REG_BITS-1:0]  set_vec, clr_vec, act_vec;
  logic [3:0]           svc_grp, svc_pin;

  genvar l;
  generate
    for (l = 0; l < NUM_LINES; l++) begin : g_line
      localparam int RI = l / 32;
      localparam int FB = ((l % 32) / 4) * 4;
      logic [3:0] code;
      assign code = cfg_q[RI*32+FB +: 4];
      always_comb begin
        case (code)
          4'd0:    set_vec[l] = ~sync2_q[l];
          4'd1:    set_vec[l] =  sync2_q[l];
          4'd2:    set_vec[l] =  prev_q[l] & ~sync2_q[l];
          4'd4:    set_vec[l] = ~prev_q[l] &  sync2_q[l];
          4'd6:    set_vec[l] =  prev_q[l] ^  sync2_q[l];
          default: set_vec[l] = 1'b0;
        endcase
      end
    end
    if (REG_BITS > NUM_LINES) begin : g_pad
      assign set_vec[REG_BITS-1:NUM_LINES] = '0;
    end
  endgenerate

  always_comb begin
    clr_vec = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (we && addr == 8'(PEND_BASE + i)) clr_vec[i*32 +: 32] = wdata;
  end

  assign act_vec = pend_q & ~mask_q;
  assign irq     = |act_vec;

  always_comb begin
    svc_grp = '0;
    svc_pin = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--)
      for (int p = 15; p >= 0; p--)
        if (act_vec[g*16+p]) begin
          svc_grp = 4'(g + 1);
          svc_pin = 4'(p);
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
      prev_q  <= '1;
      cfg_q   <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
    end else begin
      sync1_q <= line_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (we && addr == 8'(CFG_BASE + i))  cfg_q[i*32 +: 32]  <= wdata;
        if (we && addr == 8'(MASK_BASE + i)) mask_q[i*32 +: 32] <= wdata;
      end
      pend_q <= (pend_q & ~clr_vec) | set_vec;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == 8'(CFG_BASE + i))  rdata = cfg_q[i*32 +: 32];
      if (addr == 8'(MASK_BASE + i)) rdata = mask_q[i*32 +: 32];
      if (addr == 8'(PEND_BASE + i)) rdata = pend_q[i*32 +: 32];
    end
    if (addr == 8'(SVC_ADDR)) rdata = {24'd0, svc_grp, svc_pin};
  end
endmodule

// File: rtl/gpio_irq_grp_chk.sv
module gpio_irq_grp_chk #(
  parameter int REG_BITS  = 160,
  parameter int PEND_BASE = 32,
  parameter int NUM_REGS  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                we,
  input logic [7:0]          addr,
  input logic                irq,
  input logic [REG_BITS-1:0] pend_flat,
  input logic [REG_BITS-1:0] mask_flat,
  input logic [7:0]          svc
);
  logic pend_wr;
  assign pend_wr = we && (addr >= 8'(PEND_BASE)) && (addr < 8'(PEND_BASE + NUM_REGS));

  a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pend_flat == '0 && mask_flat == '1));

  a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_flat) |-> (!irq && svc == 8'd0));

  a_r6_idle_service_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> svc == 8'd0);

  a_r7_busy_service_named: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> svc[7:4] != 4'd0);

  a_r5_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_flat) & ~pend_flat)) |-> $past(pend_wr));
endmodule

bind gpio_irq_grp gpio_irq_grp_chk #(
  .REG_BITS(REG_BITS), .PEND_BASE(PEND_BASE), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .irq(irq),
  .pend_flat(pend_q), .mask_flat(mask_q), .svc({svc_grp, svc_pin})
);

// File: tb/gpio_irq_grp_tb.sv
`timescale 1ns/1ps
module gpio_irq_grp_tb;
  localparam int NG = 10;
  localparam int NL = NG * 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NL-1:0] line_in = '1;
  logic          we = 0;
  logic [7:0]    addr = 0;
  logic [31:0]   wdata = 0;
  logic [31:0]   rdata;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];

  gpio_irq_grp #(.NUM_GROUPS(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e, got;
      bit k;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      got = k ? {31'd0, irq} : rdata;
      tests++;
      if (got !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, got, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    addr = a;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #1;
    exp_q.push_back({31'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic drive(input int idx, input logic v);
    @(posedge clk); #1;
    line_in[idx] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    // R9 reset state
    rd(8'h10, 32'hFFFF_FFFF, "R9 mask0");
    rd(8'h14, 32'hFFFF_FFFF, "R9 mask4");
    rd(8'h20, 32'h0, "R9 pend0");
    rd(8'h00, 32'h0, "R9 cfg0");
    rd(8'h30, 32'h0, "R9 service");
    chk_irq(1'b0, "R9 irq");
    rd(8'h3F, 32'h0, "R1 unmapped");

    // Falling edge on line 5, synchroniser latency
    wr(8'h00, 32'h0000_0020);
    rd(8'h00, 32'h0000_0020, "R1 cfg0 readback");
    wr(8'h10, 32'hFFFF_FFDF);
    drive(5, 1'b0);
    rd(8'h20, 32'h0, "R10 edge1");
    rd(8'h20, 32'h0, "R10 edge2");
    rd(8'h20, 32'h0000_0020, "R10 edge3 R2 falling");
    chk_irq(1'b1, "R8 irq on");
    rd(8'h30, 32'h15, "R6 service g1 p5");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h0000_0020, "R5 write 0 keeps");
    wr(8'h20, 32'h0000_0020);
    rd(8'h20, 32'h0, "R5 write 1 clears");
    chk_irq(1'b0, "R8 irq off");
    drive(5, 1'b1);
    settle();
    rd(8'h20, 32'h0, "R2 falling ignores rise");

    // Rising edge on line 9, second bank of group 0
    wr(8'h00, 32'h0000_0420);
    wr(8'h10, 32'hFFFF_FDDF);
    drive(9, 1'b0);
    settle();
    rd(8'h20, 32'h0, "R2 rising ignores fall");
    drive(9, 1'b1);
    settle();
    rd(8'h20, 32'h0000_0200, "R2 rising sets");
    rd(8'h30, 32'h19, "R6 shared group pin 9");
    wr(8'h20, 32'h0000_0200);

    // Line 10 shares the field of line 9 but stays masked
    drive(10, 1'b0);
    drive(10, 1'b1);
    settle();
    rd(8'h20, 32'h0000_0400, "R3 shared field sets line 10");
    chk_irq(1'b0, "R4 masked no irq");
    rd(8'h30, 32'h0, "R4 masked no service");
    wr(8'h20, 32'h0000_0400);

    // Level high on lines 16..19 while held high
    wr(8'h10, 32'hFFF7_FDDF);
    wr(8'h00, 32'h0001_0420);
    rd(8'h20, 32'h000F_0000, "R11 level high sets R3 field");
    rd(8'h30, 32'h23, "R6 service g2 p3");
    wr(8'h20, 32'h000F_0000);
    rd(8'h20, 32'h000F_0000, "R11 clear overridden R5");
    wr(8'h00, 32'h0000_0420);
    wr(8'h20, 32'h000F_0000);
    rd(8'h20, 32'h0, "R11 cleared after level drop");

    // Both edges on line 34
    wr(8'h01, 32'h0000_0006);
    wr(8'h11, 32'hFFFF_FFFB);
    drive(34, 1'b0);
    settle();
    rd(8'h21, 32'h0000_0004, "R2 both falling");
    rd(8'h30, 32'h32, "R6 service g3 p2");
    wr(8'h21, 32'h0000_0004);
    drive(34, 1'b1);
    settle();
    rd(8'h21, 32'h0000_0004, "R2 both rising");

    // Priority across groups and within a group
    drive(5, 1'b0);
    settle();
    rd(8'h30, 32'h15, "R7 lower group wins");
    wr(8'h20, 32'h0000_0020);
    rd(8'h30, 32'h32, "R7 next group");
    wr(8'h11, 32'hFFFF_FFF9);
    drive(33, 1'b0);
    settle();
    rd(8'h21, 32'h0000_0006, "R7 both pending");
    rd(8'h30, 32'h31, "R7 lower pin wins");
    wr(8'h21, 32'h0000_0006);
    drive(5, 1'b1);
    drive(33, 1'b1);
    settle();
    wr(8'h21, 32'h0000_0006);
    rd(8'h21, 32'h0, "R5 group 2 clear");

    // Unsupported code
    wr(8'h02, 32'h0000_0003);
    wr(8'h12, 32'hFFFF_FFFE);
    drive(64, 1'b0);
    settle();
    drive(64, 1'b1);
    settle();
    rd(8'h22, 32'h0, "R12 code 3 ignored");
    chk_irq(1'b0, "R12 no irq");

    // Level low on the highest line
    wr(8'h14, 32'h7FFF_FFFF);
    drive(159, 1'b0);
    settle();
    rd(8'h24, 32'h8000_0000, "R2 low level sets");
    rd(8'h30, 32'hAF, "R6 last group pin 15");
    chk_irq(1'b1, "R8 irq high group");
    wr(8'h14, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R4 remask drops irq");
    rd(8'h30, 32'h0, "R4 remask drops service");
    rd(8'h24, 32'h8000_0000, "R4 pending kept while masked");
    drive(159, 1'b1);
    settle();
    wr(8'h24, 32'h8000_0000);
    rd(8'h24, 32'h0, "R5 final clear");

    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule